// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing half of a two-wire serial EEPROM that holds 8192 bytes. The raw clock and data lines are oversampled by a faster system clock. The block brings them into that clock domain and finds START and STOP conditions. It then runs the slave side of the protocol: it takes in a device-select byte, two memory address bytes and any number of write data bytes. It acknowledges each byte by pulling the data line low through an output enable.

Write data is handed to the write buffer one byte at a time, as a single-cycle strobe together with the address and the data. Read data comes from the array through a combinational port addressed by one shared address counter. That counter serves current-address, random and sequential reads, and it wraps from the top of memory back to zero. While the write engine reports that an internal write is in progress, the block refuses every device byte, so a host can poll for completion by watching for the acknowledge.

Top module: `eeb_bus_slave`

## Requirements
- R1: After reset, sda_oe and mem_we are low and the address counter (mem_addr) is 0, so a first current-address read returns the byte at address 0.
- R2: A device byte is acknowledged only if its top four bits are 1010 and its bits 3..1 equal strap_addr. Bit 0 selects the direction (1 = read, 0 = write). On any mismatch the ninth clock is left undriven and the block returns to idle.
- R3: A falling SDA edge while SCL is high is START, and a rising SDA edge while SCL is high is STOP. STOP always returns the block to idle, so later bytes sent without a START get no acknowledge. A START in any state restarts device-byte reception.
- R4: In a write, the first address byte supplies address bits 12..8 from its low five bits, and its top three bits are ignored. The second byte supplies bits 7..0. Each data byte, sampled on rising SCL edges MSB first, produces one single-cycle mem_we pulse carrying mem_addr and mem_wdata, after which the counter advances by one.
- R5: The block pulls SDA low during the ninth clock after an accepted device byte, after each address byte and after each write data byte.
- R6: Read data leaves MSB first and changes only after falling SCL edges. The counter advances by one after every byte sent, and it wraps from 0x1FFF to 0x0000.
- R7: A current-address read returns the byte at the last accessed address plus one. A write that carries only the two address bytes, followed by a repeated START and a read device byte, reads from the new address and produces no mem_we pulse.
- R8: While wr_busy is high, no device byte is acknowledged.
- R9: If the host does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, read back as seen on the wire |
| sda_oe | output | 1 | Pulls the data line low when high |
| strap_addr | input | 3 | Strapped low bits of the device address |
| wr_busy | input | 1 | Write engine is performing an internal write |
| mem_addr | output | 13 | Shared address counter |
| mem_rdata | input | 8 | Array byte at mem_addr |
| mem_we | output | 1 | One-cycle strobe for a write data byte |
| mem_wdata | output | 8 | Byte written with mem_we |

## Verification
The bench goes after the counter wrap at 0x1FFF. A design that saturated there, or that forgot the upper address bits, would return the wrong bytes in the third and fourth reads of a sequential read. It also sweeps every strap value against every device code and every wrong type prefix. A decoder that compared too few bits would then acknowledge a foreign device byte.

Two further cases target the control flow. One is a STOP followed by a byte that looks exactly like a valid device byte but has no START in front of it. The other is a run of host clocks after a read that the host declined to acknowledge. A block that kept its state after STOP, or kept driving after the missing acknowledge, would pull the line low where it must stay silent. Busy polling and a dummy write are also checked: a design that ignored wr_busy would acknowledge during the internal write, and one that wrote on the address bytes would raise mem_we.

// File: rtl/eeb_pkg.sv
package eeb_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_HOLD
    } st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic sel_hit(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_TYPE, strap};
    endfunction

endpackage

// File: rtl/eeb_line_sync.sv
module eeb_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] sync
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign sync[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/eeb_bus_events.sv
module eeb_bus_events
    import eeb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.scl      = scl;
        ev.sda      = sda;
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/eeb_addr_ctr.sv
module eeb_addr_ctr #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/eeb_bus_slave.sv
module eeb_bus_slave
    import eeb_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_addr,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata
);
    localparam int         HI_W     = ADDR_W - 8;
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic [1:0] line_s;
    bus_ev_t    ev;
    logic       scl_s, start_det, stop_det;

    st_e               state_q;
    logic [3:0]        cnt_q;
    logic              in_ack_q, oe_q, rw_q;
    logic [7:0]        rx_q, tx_q, wdata_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] ld_val_q;
    logic              ctr_ld_q, rd_inc_q, we_q;

    eeb_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({scl_i, sda_i}),
        .sync (line_s)
    );

    eeb_bus_events u_ev (
        .clk (clk),
        .rst (rst),
        .scl (line_s[1]),
        .sda (line_s[0]),
        .ev  (ev)
    );

    assign scl_s     = ev.scl;
    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    eeb_addr_ctr #(.W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_ld_q),
        .load_val (ld_val_q),
        .inc      (rd_inc_q | we_q),
        .q        (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            in_ack_q <= 1'b0;
            oe_q     <= 1'b0;
            rw_q     <= 1'b0;
            rx_q     <= '0;
            tx_q     <= '0;
            wdata_q  <= '0;
            hi_q     <= '0;
            ld_val_q <= '0;
            ctr_ld_q <= 1'b0;
            rd_inc_q <= 1'b0;
            we_q     <= 1'b0;
        end else begin
            ctr_ld_q <= 1'b0;
            rd_inc_q <= 1'b0;
            we_q     <= 1'b0;
            if (ev.start) begin
                state_q  <= ST_DEV;
                cnt_q    <= '0;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
            end else if (ev.stop) begin
                state_q  <= ST_IDLE;
                cnt_q    <= '0;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (!in_ack_q) begin
                            if (ev.scl_rise && cnt_q != LAST_BIT) begin
                                rx_q  <= {rx_q[6:0], ev.sda};
                                cnt_q <= cnt_q + 4'd1;
                            end else if (ev.scl_fall && cnt_q == LAST_BIT) begin
                                in_ack_q <= 1'b1;
                                oe_q     <= 1'b1;
                                case (state_q)
                                    ST_DEV: begin
                                        if (sel_hit(rx_q, strap_addr) && !wr_busy) begin
                                            rw_q <= rx_q[0];
                                        end else begin
                                            in_ack_q <= 1'b0;
                                            oe_q     <= 1'b0;
                                            cnt_q    <= '0;
                                            state_q  <= ST_IDLE;
                                        end
                                    end
                                    ST_AHI: hi_q <= rx_q[HI_W-1:0];
                                    ST_ALO: begin
                                        ctr_ld_q <= 1'b1;
                                        ld_val_q <= {hi_q, rx_q};
                                    end
                                    default: begin
                                        we_q    <= 1'b1;
                                        wdata_q <= rx_q;
                                    end
                                endcase
                            end
                        end else if (ev.scl_fall) begin
                            in_ack_q <= 1'b0;
                            cnt_q    <= '0;
                            oe_q     <= 1'b0;
                            case (state_q)
                                ST_DEV: begin
                                    if (rw_q) begin
                                        state_q <= ST_RDAT;
                                        tx_q    <= mem_rdata;
                                        oe_q    <= ~mem_rdata[7];
                                    end else begin
                                        state_q <= ST_AHI;
                                    end
                                end
                                ST_AHI:  state_q <= ST_ALO;
                                default: state_q <= ST_WDAT;
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (!in_ack_q) begin
                            if (ev.scl_rise && cnt_q != LAST_BIT) begin
                                cnt_q <= cnt_q + 4'd1;
                            end else if (ev.scl_fall) begin
                                if (cnt_q == LAST_BIT) begin
                                    oe_q     <= 1'b0;
                                    in_ack_q <= 1'b1;
                                end else if (cnt_q != 4'd0) begin
                                    tx_q <= {tx_q[6:0], 1'b0};
                                    oe_q <= ~tx_q[6];
                                end
                            end
                        end else begin
                            if (ev.scl_rise) begin
                                rd_inc_q <= 1'b1;
                                if (ev.sda) begin
                                    state_q  <= ST_HOLD;
                                    in_ack_q <= 1'b0;
                                    cnt_q    <= '0;
                                end
                            end else if (ev.scl_fall) begin
                                in_ack_q <= 1'b0;
                                cnt_q    <= '0;
                                tx_q     <= mem_rdata;
                                oe_q     <= ~mem_rdata[7];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/eeb_bus_checker.sv
module eeb_bus_checker
    import eeb_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              mem_we,
    input logic              wr_busy,
    input logic              scl_s,
    input st_e               state,
    input logic [ADDR_W-1:0] addr,
    input logic              ctr_ld,
    input logic              start_det,
    input logic              stop_det
);
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> state == ST_IDLE); // R3

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4

    AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R6

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctr_ld) && addr != $past(addr)) |-> addr == $past(addr) + 1'b1); // R6

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && state == ST_DEV) |-> !$past(wr_busy)); // R8
endmodule

bind eeb_bus_slave eeb_bus_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .wr_busy   (wr_busy),
    .scl_s     (scl_s),
    .state     (state_q),
    .addr      (mem_addr),
    .ctr_ld    (ctr_ld_q),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_eeb_bus_slave.sv
module sim_eeb_bus_slave;
    localparam int H = 8;
    localparam int Q = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [2:0]  strap = 3'd5;
    logic        busy = 1'b0;
    logic [12:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    wire         line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int nwe = 0;
    int oe_cnt = 0;
    logic [12:0] log_a [0:7];
    logic [7:0]  log_d [0:7];

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction

    assign mem_rdata = pat(mem_addr);

    eeb_bus_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
        .strap_addr(strap), .wr_busy(busy), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            log_a[nwe[2:0]] <= mem_addr;
            log_d[nwe[2:0]] <= mem_wdata;
            nwe <= nwe + 1;
        end
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q);
            scl_m = 1'b1; w(H);
            scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(H/2);
        ack = ~line;
        w(H/2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            w(2*Q);
            scl_m = 1'b1; w(H/2);
            b = {b[6:0], line};
            w(H/2);
            scl_m = 1'b0;
        end
        w(Q);
        sda_m = ~give_ack; w(Q);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    task automatic run_all();
        bit ack;
        logic [7:0] d;
        int base, oe0;
        // R1 reset state
        w(5);
        chk(sda_oe == 1'b0 && mem_we == 1'b0, "R1 outputs idle in reset", {sda_oe, mem_we}, 0);
        rst = 1'b0; w(4);
        chk(mem_addr == 13'd0, "R1 counter zero", mem_addr, 0);
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R2 read select ack", ack, 1);
        recv_byte(1'b0, d); bus_stop();
        chk(d == pat(13'd0), "R1 first current read", d, pat(13'd0));

        // R2 exhaustive strap vs select sweep
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                strap = 3'(s);
                bus_start(); send_byte({4'b1010, 3'(a), 1'b0}, ack); bus_stop();
                chk(ack == (a == s), "R2 strap match", ack, int'(a == s));
            end
        end
        strap = 3'd5;
        for (int p = 0; p < 16; p++) begin
            if (p != 10) begin
                bus_start(); send_byte({4'(p), 3'd5, 1'b0}, ack); bus_stop();
                chk(!ack, "R2 type prefix mismatch", ack, 0);
            end
        end

        // R4 R5 page of writes, junk in upper address bits
        base = nwe;
        bus_start();
        send_byte(8'hAA, ack); chk(ack, "R5 device ack", ack, 1);
        send_byte(8'hE3, ack); chk(ack, "R5 high address ack", ack, 1);
        send_byte(8'h7C, ack); chk(ack, "R5 low address ack", ack, 1);
        send_byte(8'h11, ack); chk(ack, "R5 data ack", ack, 1);
        send_byte(8'h22, ack); chk(ack, "R5 data ack", ack, 1);
        send_byte(8'h33, ack); chk(ack, "R5 data ack", ack, 1);
        bus_stop();
        chk(nwe - base == 3, "R4 write strobes", nwe - base, 3);
        for (int k = 0; k < 3; k++) begin
            chk(log_a[(base + k) % 8] == 13'h037C + 13'(k), "R4 write address",
                log_a[(base + k) % 8], 13'h037C + k);
            chk(log_d[(base + k) % 8] == 8'(8'h11 * (k + 1)), "R4 write data",
                log_d[(base + k) % 8], 8'h11 * (k + 1));
        end

        // R7 current address read after the write
        bus_start(); send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop();
        chk(d == pat(13'h037F), "R7 current read", d, pat(13'h037F));

        // R7 R6 random read then sequential across the top of memory
        base = nwe;
        bus_start(); send_byte(8'hAA, ack); send_byte(8'hFF, ack); send_byte(8'hFE, ack);
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R7 read after repeated start", ack, 1);
        recv_byte(1'b1, d); chk(d == pat(13'h1FFE), "R6 seq byte 0", d, pat(13'h1FFE));
        recv_byte(1'b1, d); chk(d == pat(13'h1FFF), "R6 seq byte 1", d, pat(13'h1FFF));
        recv_byte(1'b1, d); chk(d == pat(13'h0000), "R6 wrap to zero", d, pat(13'h0000));
        recv_byte(1'b0, d); chk(d == pat(13'h0001), "R6 after wrap", d, pat(13'h0001));
        bus_stop();
        chk(nwe == base, "R7 dummy write no strobe", nwe - base, 0);
        bus_start(); send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop();
        chk(d == pat(13'h0002), "R6 counter moved past nacked byte", d, pat(13'h0002));

        // R3 repeated start mid-address keeps counter; R9 silence after nack
        bus_start(); send_byte(8'hAA, ack); send_byte(8'h00, ack);
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R3 repeated start restarts select", ack, 1);
        recv_byte(1'b0, d);
        chk(d == pat(13'h0003), "R3 partial address not loaded", d, pat(13'h0003));
        oe0 = oe_cnt;
        send_byte(8'hFF, ack);
        send_byte(8'hFF, ack);
        chk(oe_cnt == oe0, "R9 no drive after host nack", oe_cnt - oe0, 0);
        bus_stop();

        // R3 stop returns to idle
        bus_start(); send_byte(8'hAA, ack); bus_stop();
        send_byte(8'hAA, ack);
        chk(!ack, "R3 no start after stop", ack, 0);
        bus_stop();

        // R8 busy polling
        busy = 1'b1;
        bus_start(); send_byte(8'hAA, ack); bus_stop();
        chk(!ack, "R8 busy write select", ack, 0);
        bus_start(); send_byte(8'hAB, ack); bus_stop();
        chk(!ack, "R8 busy read select", ack, 0);
        busy = 1'b0;
        bus_start(); send_byte(8'hAA, ack); bus_stop();
        chk(ack, "R8 ack after busy clears", ack, 1);
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule